// File: doc/BRIEF.md
# SPI Flash Memory-Mapped Read Engine

This block serves read requests from a host port by running one single-bit SPI transaction on a serial flash device. It handles one transaction at a time. Each accepted request selects one of several chip selects and takes that select's 32-bit control word. The block then lowers the chip select and shifts out the read opcode and a three- or four-byte address. Next it sends from zero to seven dummy bytes held at all ones. Last, it clocks in one to four data bytes while driving the data line low.

The received bytes come back as a little-endian word. They are returned in a one-cycle response pulse as soon as chip select has been released. The serial clock runs at the system clock divided by `2**CLK_DIV_LOG2` and uses SPI mode 0: the clock idles low, the output changes on the falling edge and the input is sampled on the rising edge.

The controller is a three-state machine:
- `ST_IDLE` waits for a request. It moves to `ST_XFER` when `req_valid` is high and `req_ready` is high.
- `ST_XFER` shifts bytes. It moves to `ST_GAP` on the falling clock edge that ends the last data byte.
- `ST_GAP` keeps chip select high for one serial clock period and raises the response. It returns to `ST_IDLE` when that period ends.

Top module: `spi_flash_rd_engine`

## Requirements
- R1: After reset, all `cs_n` lines are high, `sck` is low, `req_ready` is high and `rsp_valid` is low.
- R2: A transaction sends bytes in this order: the opcode from control bits [23:16], then the address, then the dummy bytes, then the data bytes. Each byte is sent MSB first in SPI mode 0: `sck` idles low, `mosi` changes after a falling edge, and `miso` is sampled on the rising edge.
- R3: When control bit 13 is 1, four address bytes are sent, `req_addr[31:24]` first. When it is 0, three bytes are sent, `req_addr[23:16]` first.
- R4: When control bits [1:0] are not 0, the number of dummy bytes is the 3-bit value {bit 14, bits [7:6]}, from 0 to 7. Each dummy byte is 0xFF.
- R5: When control bits [1:0] are 0 (plain read mode), no dummy bytes are sent, whatever bits 14 and [7:6] hold.
- R6: `req_size` value n reads n+1 data bytes, and `mosi` is 0 during them. Data byte i lands in `rsp_data[8i+7:8i]`, and the unused upper bytes are zero.
- R7: When control bit 2 is 1, the selected `cs_n` line stays high for the whole transaction. The clocking still runs, and the response still arrives.
- R8: Only the line `cs_n[req_cs]` may go low, and at most one line is low at any time.
- R9: `rsp_valid` is a single-cycle pulse in the first cycle that chip select is high after the last data bit. `req_ready` stays low from acceptance until the gap ends.
- R10: Each `sck` high phase lasts `2**(CLK_DIV_LOG2-1)` clocks. Chip select stays high for at least `2**CLK_DIV_LOG2` clocks between two transactions.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| req_valid | input | 1 | Read request present |
| req_ready | output | 1 | Engine idle, request accepted this cycle if valid |
| req_cs | input | CS_W | Chip-select index of the request |
| req_addr | input | 32 | Flash byte address |
| req_size | input | 2 | Data bytes minus one |
| ctrl_regs | input | NUM_CS*32 | One control word per chip select, select k in bits [32k+31:32k] |
| rsp_valid | output | 1 | Response pulse |
| rsp_data | output | 32 | Little-endian read data |
| sck | output | 1 | Serial clock |
| cs_n | output | NUM_CS | Active-low chip selects |
| mosi | output | 1 | Serial data to flash |
| miso | input | 1 | Serial data from flash |

## Verification
A request is accepted on the clock edge where `req_valid` and `req_ready` are both high. Chip select falls after that same edge. The response pulse comes 8 x (1 + address bytes + dummies + data bytes) x `2**CLK_DIV_LOG2` clocks later, in the cycle where chip select rises. The bench therefore polls on falling clock edges for the pulse. At the pulse it checks the response word, that chip select is now high and was low one cycle earlier, and then that the pulse is gone a cycle later. A flash model captures `mosi` on rising `sck` and drives `miso` after falling `sck`, and its captured byte stream is compared with the expected sequence at each response.

// File: rtl/spi_rd_pkg.sv
package spi_rd_pkg;

    typedef enum logic [1:0] {
        ST_IDLE = 2'd0,
        ST_XFER = 2'd1,
        ST_GAP  = 2'd2
    } rd_state_t;

    typedef struct packed {
        logic [7:0] opcode;
        logic       addr4;
        logic [2:0] dummies;
        logic       hold_off;
    } rd_cfg_t;

    // Decode one control word; plain read mode (mode field 0) drops dummies.
    function automatic rd_cfg_t decode_ctrl(input logic [31:0] w);
        rd_cfg_t c;
        c.opcode   = w[23:16];
        c.addr4    = w[13];
        c.dummies  = (w[1:0] == 2'd0) ? 3'd0 : {w[14], w[7:6]};
        c.hold_off = w[2];
        return c;
    endfunction

    // Byte sent at position idx of a transaction.
    function automatic logic [7:0] tx_byte(input logic [4:0] idx, input rd_cfg_t c,
                                           input logic [31:0] addr);
        logic [4:0] alen;
        logic [4:0] shift;
        alen = c.addr4 ? 5'd4 : 5'd3;
        if (idx == 5'd0) begin
            return c.opcode;
        end else if (idx <= alen) begin
            shift = alen - idx;
            return 8'(addr >> {shift, 3'b000});
        end else if (idx <= alen + 5'(c.dummies)) begin
            return 8'hFF;
        end
        return 8'h00;
    endfunction

endpackage

// File: rtl/spi_sck_div.sv
module spi_sck_div #(
    parameter int DIV_LOG2 = 2
) (
    input  logic clk,
    input  logic rst_n,
    input  logic run,
    output logic sck_lvl,
    output logic rise_tick,
    output logic fall_tick,
    output logic phase_start
);
    localparam int HALF = 2 ** (DIV_LOG2 - 1);

    logic [DIV_LOG2-1:0] cnt;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)   cnt <= '0;
        else if (run) cnt <= cnt + 1'b1;
        else          cnt <= '0;
    end

    assign sck_lvl     = cnt[DIV_LOG2-1];
    assign rise_tick   = run && (cnt == DIV_LOG2'(HALF - 1));
    assign fall_tick   = run && (&cnt);
    assign phase_start = (cnt == '0);
endmodule

// File: rtl/spi_byte_shift.sv
module spi_byte_shift (
    input  logic       clk,
    input  logic       rst_n,
    input  logic       load,
    input  logic [7:0] load_byte,
    input  logic       shift_out,
    input  logic       sample,
    input  logic       miso,
    output logic       mosi,
    output logic [7:0] rx_next
);
    logic [7:0] tx_sr;
    logic [7:0] rx_sr;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)         tx_sr <= '0;
        else if (load)      tx_sr <= load_byte;
        else if (shift_out) tx_sr <= {tx_sr[6:0], 1'b0};
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)      rx_sr <= '0;
        else if (sample) rx_sr <= rx_next;
    end

    assign mosi    = tx_sr[7];
    assign rx_next = {rx_sr[6:0], miso};
endmodule

// File: rtl/spi_flash_rd_engine.sv
module spi_flash_rd_engine
    import spi_rd_pkg::*;
#(
    parameter int NUM_CS       = 2,
    parameter int CLK_DIV_LOG2 = 2,
    localparam int CS_W        = (NUM_CS > 1) ? $clog2(NUM_CS) : 1
) (
    input  logic                 clk,
    input  logic                 rst_n,
    input  logic                 req_valid,
    output logic                 req_ready,
    input  logic [CS_W-1:0]      req_cs,
    input  logic [31:0]          req_addr,
    input  logic [1:0]           req_size,
    input  logic [NUM_CS*32-1:0] ctrl_regs,
    output logic                 rsp_valid,
    output logic [31:0]          rsp_data,
    output logic                 sck,
    output logic [NUM_CS-1:0]    cs_n,
    output logic                 mosi,
    input  logic                 miso
);
    rd_state_t  state, state_nx;
    rd_cfg_t    cfg_q, req_cfg;
    logic [31:0] addr_q;
    logic [CS_W-1:0] cs_q;
    logic [2:0] bit_idx;
    logic [4:0] byte_idx, data_start, last_idx;
    logic [31:0] word_q;
    logic       accept, end_byte, last_byte;
    logic       sck_lvl, rise_tick, fall_tick, phase_start;
    logic [7:0] rx_next, load_byte;
    logic [4:0] data_pos;

    assign req_cfg = decode_ctrl(ctrl_regs[32*req_cs +: 32]);
    assign accept  = (state == ST_IDLE) && req_valid;

    spi_sck_div #(.DIV_LOG2(CLK_DIV_LOG2)) div_i (
        .clk(clk), .rst_n(rst_n), .run(state != ST_IDLE),
        .sck_lvl(sck_lvl), .rise_tick(rise_tick), .fall_tick(fall_tick),
        .phase_start(phase_start)
    );

    assign end_byte  = (state == ST_XFER) && fall_tick && (bit_idx == 3'd7);
    assign last_byte = (byte_idx == last_idx);
    assign load_byte = accept ? req_cfg.opcode : tx_byte(byte_idx + 5'd1, cfg_q, addr_q);

    spi_byte_shift sh_i (
        .clk(clk), .rst_n(rst_n),
        .load(accept || (end_byte && !last_byte)), .load_byte(load_byte),
        .shift_out((state == ST_XFER) && fall_tick),
        .sample((state == ST_XFER) && rise_tick),
        .miso(miso), .mosi(mosi), .rx_next(rx_next)
    );

    // State register.
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) state <= ST_IDLE;
        else        state <= state_nx;
    end

    always_comb begin
        state_nx = state;
        unique case (state)
            ST_IDLE: if (accept)                  state_nx = ST_XFER;
            ST_XFER: if (end_byte && last_byte)   state_nx = ST_GAP;
            ST_GAP:  if (fall_tick)               state_nx = ST_IDLE;
            default:                              state_nx = ST_IDLE;
        endcase
    end

    // Transaction bookkeeping.
    assign data_pos = byte_idx - data_start;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            cfg_q      <= '0;
            addr_q     <= '0;
            cs_q       <= '0;
            bit_idx    <= '0;
            byte_idx   <= '0;
            data_start <= '0;
            last_idx   <= '0;
            word_q     <= '0;
        end else if (accept) begin
            cfg_q      <= req_cfg;
            addr_q     <= req_addr;
            cs_q       <= req_cs;
            bit_idx    <= '0;
            byte_idx   <= '0;
            data_start <= 5'd1 + (req_cfg.addr4 ? 5'd4 : 5'd3) + 5'(req_cfg.dummies);
            last_idx   <= 5'd1 + (req_cfg.addr4 ? 5'd4 : 5'd3) + 5'(req_cfg.dummies)
                          + 5'(req_size);
            word_q     <= '0;
        end else if (state == ST_XFER) begin
            if (rise_tick && bit_idx == 3'd7 && byte_idx >= data_start)
                word_q[{data_pos[1:0], 3'b000} +: 8] <= rx_next;
            if (fall_tick) begin
                bit_idx <= bit_idx + 3'd1;
                if (bit_idx == 3'd7) byte_idx <= byte_idx + 5'd1;
            end
        end
    end

    // Outputs.
    always_comb begin
        req_ready = (state == ST_IDLE);
        sck       = (state == ST_XFER) && sck_lvl;
        rsp_valid = (state == ST_GAP) && phase_start;
        rsp_data  = word_q;
    end

    for (genvar k = 0; k < NUM_CS; k++) begin : g_cs
        assign cs_n[k] = !((state == ST_XFER) && (cs_q == CS_W'(k)) && !cfg_q.hold_off);
    end
endmodule

// File: rtl/spi_flash_rd_chk.sv
module spi_flash_rd_chk #(
    parameter int NUM_CS = 2
) (
    input logic              clk,
    input logic              rst_n,
    input logic              req_ready,
    input logic              rsp_valid,
    input logic              sck,
    input logic [NUM_CS-1:0] cs_n
);
    AST_CS_ONE_LOW: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0(~cs_n)); // R8
    AST_SCK_IDLE_LOW: assert property (@(posedge clk) disable iff (!rst_n)
        req_ready |-> !sck); // R2
    AST_BUSY_WHILE_SEL: assert property (@(posedge clk) disable iff (!rst_n)
        (!(&cs_n)) |-> !req_ready); // R9
    AST_RSP_CS_HIGH: assert property (@(posedge clk) disable iff (!rst_n)
        rsp_valid |-> ((&cs_n) && !req_ready)); // R9
    AST_RSP_SINGLE: assert property (@(posedge clk) disable iff (!rst_n)
        rsp_valid |=> !rsp_valid); // R9
    AST_NO_SEL_AFTER_RSP: assert property (@(posedge clk) disable iff (!rst_n)
        rsp_valid |=> (&cs_n)); // R10
endmodule

bind spi_flash_rd_engine spi_flash_rd_chk #(.NUM_CS(NUM_CS)) chk_i (
    .clk(clk), .rst_n(rst_n), .req_ready(req_ready), .rsp_valid(rsp_valid),
    .sck(sck), .cs_n(cs_n)
);

// File: tb/spi_flash_rd_engine_tb_top.sv
module spi_flash_rd_engine_tb_top;
    localparam int NUM_CS = 2;
    localparam int DIVL   = 2;
    localparam int PER    = 2 ** DIVL;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic req_valid = 1'b0;
    logic req_ready;
    logic [0:0] req_cs = '0;
    logic [31:0] req_addr = '0;
    logic [1:0] req_size = '0;
    logic [NUM_CS*32-1:0] ctrl_regs = '0;
    logic rsp_valid;
    logic [31:0] rsp_data;
    logic sck;
    logic [NUM_CS-1:0] cs_n;
    logic mosi;
    logic miso = 1'b1;

    int n_chk = 0;
    int n_fail = 0;

    always #2 clk = ~clk;

    spi_flash_rd_engine #(.NUM_CS(NUM_CS), .CLK_DIV_LOG2(DIVL)) dut_i (.*);

    task automatic chk(input bit ok, input string req, input logic [31:0] act,
                       input logic [31:0] exp);
        n_chk++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s actual=%h expected=%h", req, act, exp);
        end
    endtask

    function automatic logic [7:0] mem_byte(input logic [31:0] a);
        return a[7:0] ^ a[15:8] ^ {a[23:20], a[27:24]} ^ 8'hA5;
    endfunction

    // Flash model.
    logic flash_sel;
    assign flash_sel = ~&cs_n;
    int nb = 0;
    int m_dstart = 0;
    logic [31:0] m_addr = '0;
    logic [7:0] shreg = '0;
    logic [7:0] cap [0:31];

    function automatic logic tx_bit(input int n);
        logic [7:0] b;
        if (n / 8 >= m_dstart) b = mem_byte(m_addr + 32'(n / 8 - m_dstart));
        else b = 8'h00;
        return b[7 - n % 8];
    endfunction

    always @(posedge flash_sel) begin nb = 0; miso = tx_bit(0); end
    always @(negedge flash_sel) miso = 1'b1;
    always @(posedge sck) if (flash_sel) begin
        shreg = {shreg[6:0], mosi};
        nb++;
        if (nb % 8 == 0 && nb <= 256) cap[nb / 8 - 1] = shreg;
    end
    always @(negedge sck) if (flash_sel) miso = tx_bit(nb);

    // Monitors: sck high width, chip-select gap, select index.
    int hi_cnt = 0;
    int gap_cnt = 0;
    bit had_txn = 0;
    logic [0:0] cur_cs = '0;
    always @(negedge clk) if (rst_n) begin
        if (sck) hi_cnt++;
        else if (hi_cnt != 0) begin
            chk(hi_cnt == PER / 2, "R10 sck high width", 32'(hi_cnt), 32'(PER / 2));
            hi_cnt = 0;
        end
        if (flash_sel) begin
            if (gap_cnt != 0 && had_txn)
                chk(gap_cnt >= PER, "R10 cs gap", 32'(gap_cnt), 32'(PER));
            gap_cnt = 0;
            chk(cs_n == ~(NUM_CS'(1) << cur_cs), "R8 select line", 32'(cs_n),
                32'(~(NUM_CS'(1) << cur_cs)));
        end else begin
            gap_cnt++;
        end
    end

    function automatic logic [31:0] mk_ctrl(input logic [7:0] op, input logic [1:0] mode,
                                            input bit a4, input logic [2:0] dm, input bit stop);
        return {8'h00, op, 1'b0, dm[2], a4, 5'd0, dm[1:0], 3'd0, stop, mode};
    endfunction

    task automatic run_txn(input logic [0:0] cs, input logic [31:0] addr,
                           input logic [1:0] size, input logic [31:0] ctrl);
        int alen, dm, tot, cyc;
        logic [7:0] exp_b [0:31];
        logic [31:0] exp_w;
        bit stop, prev;
        stop = ctrl[2];
        alen = ctrl[13] ? 4 : 3;
        dm   = (ctrl[1:0] == 2'd0) ? 0 : int'({ctrl[14], ctrl[7:6]});
        tot  = 1 + alen + dm + int'(size) + 1;
        exp_b[0] = ctrl[23:16];
        for (int i = 0; i < alen; i++) exp_b[1 + i] = addr[8 * (alen - 1 - i) +: 8];
        for (int i = 0; i < dm; i++) exp_b[1 + alen + i] = 8'hFF;
        for (int i = 0; i <= int'(size); i++) exp_b[1 + alen + dm + i] = 8'h00;
        m_dstart = 1 + alen + dm;
        m_addr   = (alen == 4) ? addr : {8'h00, addr[23:0]};
        exp_w = '0;
        for (int i = 0; i <= int'(size); i++)
            exp_w[8 * i +: 8] = stop ? 8'hFF : mem_byte(m_addr + 32'(i));
        while (!req_ready) @(negedge clk);
        ctrl_regs[32 * cs +: 32] = ctrl;
        ctrl_regs[32 * (1 - cs) +: 32] = $urandom;
        cur_cs = cs; req_cs = cs; req_addr = addr; req_size = size; req_valid = 1'b1;
        nb = 0;
        @(negedge clk);
        req_valid = 1'b0;
        chk(!req_ready, "R9 ready low after accept", 32'(req_ready), 0);
        cyc = 0; prev = flash_sel;
        while (!rsp_valid && cyc < 4000) begin
            prev = flash_sel;
            @(negedge clk);
            cyc++;
            if (stop) chk(&cs_n, "R7 cs held high", 32'(cs_n), 32'(2 ** NUM_CS - 1));
        end
        chk(rsp_valid, "R9 response arrives", 32'(rsp_valid), 1);
        chk(rsp_data == exp_w, "R6 response word", rsp_data, exp_w);
        chk((&cs_n) && (stop || prev), "R9 pulse as cs rises", {30'd0, prev, &cs_n}, 32'd3);
        if (!stop) begin
            chk(nb == 8 * tot, "R2 sck edge count", 32'(nb), 32'(8 * tot));
            for (int i = 0; i < tot; i++)
                chk(cap[i] == exp_b[i], (i <= alen) ? "R3 opcode/address byte" :
                    (i <= alen + dm) ? "R4 dummy byte" : "R6 data-phase mosi",
                    32'(cap[i]), 32'(exp_b[i]));
        end
        @(negedge clk);
        chk(!rsp_valid, "R9 single pulse", 32'(rsp_valid), 0);
        had_txn = 1;
    endtask

    initial begin
        #200000;
        n_fail++;
        $display("FAIL watchdog expired actual=running expected=done");
        $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
        $finish;
    end

    initial begin
        void'($urandom(32'h5EED_0042));
        repeat (3) @(negedge clk);
        chk(cs_n == '1, "R1 cs_n reset", 32'(cs_n), 32'(2 ** NUM_CS - 1));
        chk(!sck && req_ready && !rsp_valid, "R1 idle outputs",
            {29'd0, sck, req_ready, rsp_valid}, 32'd2);
        rst_n = 1'b1;
        @(negedge clk);
        // R5: plain read mode ignores a non-zero dummy field.
        run_txn(1'b0, 32'h0012_3456, 2'd3, mk_ctrl(8'h03, 2'd0, 1'b0, 3'd7, 1'b0));
        // R3 and R4: four-byte address, maximum dummies.
        run_txn(1'b1, 32'hA1B2_C3D4, 2'd3, mk_ctrl(8'h0C, 2'd1, 1'b1, 3'd7, 1'b0));
        // R4: dummy count split field, value 4 then 3.
        run_txn(1'b0, 32'h00FF_FFFF, 2'd0, mk_ctrl(8'h0B, 2'd2, 1'b0, 3'd4, 1'b0));
        run_txn(1'b1, 32'h0000_0000, 2'd1, mk_ctrl(8'h0B, 2'd3, 1'b0, 3'd3, 1'b0));
        // R7: hold-off bit keeps the line high.
        run_txn(1'b1, 32'h0000_1000, 2'd2, mk_ctrl(8'h0B, 2'd1, 1'b0, 3'd1, 1'b1));
        // Back-to-back after hold-off, R10 gap.
        run_txn(1'b0, 32'h7654_3210, 2'd2, mk_ctrl(8'h13, 2'd1, 1'b1, 3'd0, 1'b0));
        for (int t = 0; t < 30; t++) begin
            logic [31:0] r;
            r = $urandom;
            run_txn(r[0], $urandom, r[2:1],
                    mk_ctrl(r[15:8], r[4:3], r[5], r[18:16], 1'b0));
        end
        $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
        $finish;
    end
endmodule